// File: doc/BRIEF.md
# Page-Translated DMA Channel Engine

This block is one DMA channel that moves bytes between a peripheral byte stream and system memory. The channel works on logical DMA addresses. Before any byte reaches memory, each logical address is mapped to a physical one through a page table in memory. The page size is 4 KiB. Each table slot is 8 bytes wide, and the first 32 bits of the slot hold the physical page.

Software sets up the channel through a small word-indexed register file. These registers hold a mode word, an enable word, a byte count, a logical start address, a table base and a table limit. The peripheral side then asks for a transfer of a given length in a given direction. The engine first checks the run and direction bits. It then fetches a table entry each time it enters a new page, and it issues transfers of 255, 15 or 1 bytes to memory. The transfer size depends on the alignment of the physical address and on how many bytes the request still has. When the transfer ends, the engine pulses done and reports how many bytes it moved.

Top module: `pgxl_dma_chan`

## Requirements
- R1: The registers are indexed by reg_idx: 0 = mode, 1 = enable (bit 0 is run, bit 1 set means memory-to-device), 2 = byte count, 3 = logical start, 4 = table base, 5 = table limit. Each one reads back what was last written to it. Indices 6 and 7 always read zero. All registers reset to zero.
- R2: A table lookup reads the address table_base + (logical >> 12) * 8. The 32-bit entry is built from four byte lanes, where lane 0 is tbl_rd_data[7:0]. With big_endian = 0 the lanes are used as they come. With big_endian = 1, lane 0 becomes the most significant byte.
- R3: The physical address is the entry with its low 12 bits cleared, ORed with the low 12 bits of the logical address.
- R4: A lookup is made the first time a request enters a page. The fetched entry is reused for all later transfers in the same 4 KiB page, and a new lookup is made when the logical address crosses into another page.
- R5: A request with req_to_mem = 1 is accepted only when enable bit 1 is clear. A request with req_to_mem = 0 is accepted only when enable bit 1 is set. A refused request pulses done with zero bytes, makes no lookup and no transfer, and leaves the count register unchanged.
- R6: When enable bit 0 (run) is clear, every request is refused in the same way as in R5.
- R7: A transfer is 255 bytes when physical[7:0] is zero and at least 255 request bytes remain. Otherwise it is 15 bytes when physical[3:0] is zero and at least 15 bytes remain. Otherwise it is 1 byte.
- R8: Before each transfer the engine checks two conditions: the logical address must be below start + count, and the bytes moved must be fewer than the request length. The transfer goes ahead only if both hold, so a burst chosen by R7 may run past start + count.
- R9: On normal completion, done is high for exactly one cycle, done_bytes gives the bytes moved, and the count register reads zero afterwards.
- R10: If a table fetch returns tbl_rd_err, the transfer stops with no further transfers. done pulses with done_err = 1 and done_bytes equal to the bytes moved so far, and the count register is left unchanged.
- R11: xfer_valid, xfer_addr and xfer_len stay stable until xfer_ready. xfer_write equals req_to_mem.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| big_endian | input | 1 | Byte order of table entries |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| req_start | input | 1 | Start a request (one-cycle pulse, taken while idle) |
| req_to_mem | input | 1 | 1 = device to memory, 0 = memory to device |
| req_len | input | 16 | Request length in bytes |
| tbl_rd_req | output | 1 | Table read request, held until tbl_rd_valid |
| tbl_rd_addr | output | 32 | Table entry address |
| tbl_rd_valid | input | 1 | Table read data valid |
| tbl_rd_data | input | 32 | Table entry byte lanes |
| tbl_rd_err | input | 1 | Table read error, qualified by tbl_rd_valid |
| xfer_valid | output | 1 | Memory transfer request |
| xfer_ready | input | 1 | Memory transfer accepted |
| xfer_addr | output | 32 | Physical start address of the transfer |
| xfer_len | output | 8 | Transfer length: 1, 15 or 255 |
| xfer_write | output | 1 | 1 = write memory |
| done | output | 1 | One-cycle completion pulse |
| done_err | output | 1 | Completion was caused by a table fault |
| done_bytes | output | 16 | Bytes moved by the request |

## Verification
The bench uses the default parameters: 32-bit addresses, a 16-bit request length, 4 KiB pages, and burst alignments of 256 and 16 bytes. These values let it reach full 255-byte bursts inside a 300-byte request and reuse of one cached entry across them. They also let it cross a page boundary only two bytes after the start, and make a burst overrun the programmed count. The table model in the bench ignores the low 12 entry bits, which are set to a non-zero value, and it can fault on any chosen page.

// File: rtl/pgxl_pkg.sv
package pgxl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_LOOKUP,
    ST_XFER,
    ST_FINISH
  } pgxl_state_e;

  localparam logic [2:0] IDX_MODE   = 3'd0;
  localparam logic [2:0] IDX_ENABLE = 3'd1;
  localparam logic [2:0] IDX_COUNT  = 3'd2;
  localparam logic [2:0] IDX_START  = 3'd3;
  localparam logic [2:0] IDX_TBASE  = 3'd4;
  localparam logic [2:0] IDX_TLIMIT = 3'd5;

  localparam int ENA_RUN_BIT = 0;
  localparam int ENA_DIR_BIT = 1;

endpackage

// File: rtl/pgxl_regs.sv
module pgxl_regs
  import pgxl_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [2:0]    idx,
  input  logic [AW-1:0] wdata,
  input  logic          clr_count,
  output logic [AW-1:0] rdata,
  output logic          run,
  output logic          mem_to_dev,
  output logic [AW-1:0] count,
  output logic [AW-1:0] start,
  output logic [AW-1:0] tbl_base
);

  logic [AW-1:0] mode_q, mode_d;
  logic [AW-1:0] ena_q, ena_d;
  logic [AW-1:0] cnt_q, cnt_d;
  logic [AW-1:0] start_q, start_d;
  logic [AW-1:0] tbase_q, tbase_d;
  logic [AW-1:0] tlim_q, tlim_d;

  always_comb begin
    mode_d  = mode_q;
    ena_d   = ena_q;
    cnt_d   = cnt_q;
    start_d = start_q;
    tbase_d = tbase_q;
    tlim_d  = tlim_q;
    if (wr) begin
      case (idx)
        IDX_MODE:   mode_d  = wdata;
        IDX_ENABLE: ena_d   = wdata;
        IDX_COUNT:  cnt_d   = wdata;
        IDX_START:  start_d = wdata;
        IDX_TBASE:  tbase_d = wdata;
        IDX_TLIMIT: tlim_d  = wdata;
        default: ;
      endcase
    end
    // Completion clear wins over a same-cycle software write.
    if (clr_count) cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      ena_q   <= '0;
      cnt_q   <= '0;
      start_q <= '0;
      tbase_q <= '0;
      tlim_q  <= '0;
    end else begin
      mode_q  <= mode_d;
      ena_q   <= ena_d;
      cnt_q   <= cnt_d;
      start_q <= start_d;
      tbase_q <= tbase_d;
      tlim_q  <= tlim_d;
    end
  end

  always_comb begin
    case (idx)
      IDX_MODE:   rdata = mode_q;
      IDX_ENABLE: rdata = ena_q;
      IDX_COUNT:  rdata = cnt_q;
      IDX_START:  rdata = start_q;
      IDX_TBASE:  rdata = tbase_q;
      IDX_TLIMIT: rdata = tlim_q;
      default:    rdata = '0;
    endcase
  end

  assign run        = ena_q[ENA_RUN_BIT];
  assign mem_to_dev = ena_q[ENA_DIR_BIT];
  assign count      = cnt_q;
  assign start      = start_q;
  assign tbl_base   = tbase_q;

  // R9: a completion clear leaves the count at zero on the next cycle
  a_r9_count_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    clr_count |=> (cnt_q == '0));

endmodule

// File: rtl/pgxl_xlate.sv
module pgxl_xlate #(
  parameter int AW        = 32,
  parameter int PAGE_BITS = 12,
  parameter int ENT_LOG2  = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          load,
  input  logic          big_endian,
  input  logic [AW-1:0] lanes,
  input  logic [AW:0]   log_addr,
  input  logic [AW-1:0] tbl_base,
  output logic          hit,
  output logic [AW-1:0] tbl_addr,
  output logic [AW-1:0] phys
);

  localparam int NB     = AW / 8;
  localparam int FRAME_W = AW - PAGE_BITS;
  localparam int TAG_W  = AW + 1 - PAGE_BITS;

  logic [AW-1:0]      swapped;
  logic [AW-1:0]      entry;
  logic [FRAME_W-1:0] frame_q, frame_d;
  logic [TAG_W-1:0]   tag_q, tag_d;
  logic               vld_q, vld_d;
  logic               ent_unused;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign swapped[8*b +: 8] = lanes[8*(NB-1-b) +: 8];
  end

  assign entry      = big_endian ? swapped : lanes;
  assign ent_unused = ^entry[PAGE_BITS-1:0];

  always_comb begin
    frame_d = frame_q;
    tag_d   = tag_q;
    vld_d   = vld_q;
    if (flush) begin
      vld_d = 1'b0;
    end else if (load) begin
      frame_d = entry[AW-1:PAGE_BITS];
      tag_d   = log_addr[AW:PAGE_BITS];
      vld_d   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
      tag_q   <= '0;
      vld_q   <= 1'b0;
    end else begin
      frame_q <= frame_d;
      tag_q   <= tag_d;
      vld_q   <= vld_d;
    end
  end

  assign hit      = vld_q && (tag_q == log_addr[AW:PAGE_BITS]);
  assign tbl_addr = tbl_base +
                    AW'({log_addr[AW-1:PAGE_BITS], {ENT_LOG2{1'b0}}});
  assign phys     = {frame_q, log_addr[PAGE_BITS-1:0]};

  // R4: a freshly loaded entry serves the page it was fetched for
  a_r4_load_hits: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !flush) |=> hit);

endmodule

// File: rtl/pgxl_sizer.sv
module pgxl_sizer #(
  parameter int LEN_W   = 16,
  parameter int BL_LOG2 = 8,
  parameter int BS_LOG2 = 4
) (
  input  logic [BL_LOG2-1:0] phys_low,
  input  logic [LEN_W:0]     remaining,
  output logic [BL_LOG2-1:0] size
);

  localparam int BIG_N   = (1 << BL_LOG2) - 1;
  localparam int SMALL_N = (1 << BS_LOG2) - 1;

  logic big_ok, small_ok;

  assign big_ok   = (phys_low == '0) && (remaining >= (LEN_W+1)'(BIG_N));
  assign small_ok = (phys_low[BS_LOG2-1:0] == '0) &&
                    (remaining >= (LEN_W+1)'(SMALL_N));

  always_comb begin
    if (big_ok)        size = BL_LOG2'(BIG_N);
    else if (small_ok) size = BL_LOG2'(SMALL_N);
    else               size = BL_LOG2'(1);
  end

endmodule

// File: rtl/pgxl_dma_chan.sv
module pgxl_dma_chan
  import pgxl_pkg::*;
#(
  parameter int AW        = 32,
  parameter int LEN_W     = 16,
  parameter int PAGE_BITS = 12,
  parameter int ENT_LOG2  = 3,
  parameter int BL_LOG2   = 8,
  parameter int BS_LOG2   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               big_endian,
  input  logic               reg_wr,
  input  logic [2:0]         reg_idx,
  input  logic [AW-1:0]      reg_wdata,
  output logic [AW-1:0]      reg_rdata,
  input  logic               req_start,
  input  logic               req_to_mem,
  input  logic [LEN_W-1:0]   req_len,
  output logic               tbl_rd_req,
  output logic [AW-1:0]      tbl_rd_addr,
  input  logic               tbl_rd_valid,
  input  logic [AW-1:0]      tbl_rd_data,
  input  logic               tbl_rd_err,
  output logic               xfer_valid,
  input  logic               xfer_ready,
  output logic [AW-1:0]      xfer_addr,
  output logic [BL_LOG2-1:0] xfer_len,
  output logic               xfer_write,
  output logic               done,
  output logic               done_err,
  output logic [LEN_W-1:0]   done_bytes
);

  localparam int BIG_N   = (1 << BL_LOG2) - 1;
  localparam int SMALL_N = (1 << BS_LOG2) - 1;

  // Reset: asynchronous assertion, synchronous release
  logic [1:0] rs_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s_n = rs_q[1];

  pgxl_state_e   st_q, st_d;
  logic [AW:0]   log_q, log_d;
  logic [AW:0]   end_q, end_d;
  logic [LEN_W:0] moved_q, moved_d;
  logic [LEN_W:0] len_q, len_d;
  logic          wr_q, wr_d;
  logic          ferr_q, ferr_d;
  logic          fclr_q, fclr_d;

  logic          run, mem_to_dev, accept;
  logic [AW-1:0] cnt, start, tbase;
  logic          hit, flush, load;
  logic [AW-1:0] phys;
  logic [BL_LOG2-1:0] size;
  logic          clr_count;

  pgxl_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_s_n), .wr(reg_wr), .idx(reg_idx),
    .wdata(reg_wdata), .clr_count(clr_count), .rdata(reg_rdata),
    .run(run), .mem_to_dev(mem_to_dev), .count(cnt), .start(start),
    .tbl_base(tbase)
  );

  pgxl_xlate #(.AW(AW), .PAGE_BITS(PAGE_BITS), .ENT_LOG2(ENT_LOG2)) u_xlate (
    .clk(clk), .rst_n(rst_s_n), .flush(flush), .load(load),
    .big_endian(big_endian), .lanes(tbl_rd_data), .log_addr(log_q),
    .tbl_base(tbase), .hit(hit), .tbl_addr(tbl_rd_addr), .phys(phys)
  );

  pgxl_sizer #(.LEN_W(LEN_W), .BL_LOG2(BL_LOG2), .BS_LOG2(BS_LOG2)) u_sizer (
    .phys_low(phys[BL_LOG2-1:0]), .remaining(len_q - moved_q), .size(size)
  );

  assign accept = run && (req_to_mem != mem_to_dev);
  assign flush  = (st_q == ST_IDLE) && req_start;
  assign load   = (st_q == ST_LOOKUP) && tbl_rd_valid && !tbl_rd_err;

  always_comb begin
    st_d    = st_q;
    log_d   = log_q;
    end_d   = end_q;
    moved_d = moved_q;
    len_d   = len_q;
    wr_d    = wr_q;
    ferr_d  = ferr_q;
    fclr_d  = fclr_q;
    case (st_q)
      ST_IDLE: begin
        if (req_start) begin
          moved_d = '0;
          ferr_d  = 1'b0;
          fclr_d  = 1'b0;
          if (accept) begin
            log_d = {1'b0, start};
            end_d = {1'b0, start} + {1'b0, cnt};
            len_d = {1'b0, req_len};
            wr_d  = req_to_mem;
            st_d  = ST_CHECK;
          end else begin
            st_d  = ST_FINISH;
          end
        end
      end
      ST_CHECK: begin
        if ((log_q < end_q) && (moved_q < len_q)) begin
          st_d = hit ? ST_XFER : ST_LOOKUP;
        end else begin
          fclr_d = 1'b1;
          st_d   = ST_FINISH;
        end
      end
      ST_LOOKUP: begin
        if (tbl_rd_valid) begin
          if (tbl_rd_err) begin
            ferr_d = 1'b1;
            st_d   = ST_FINISH;
          end else begin
            st_d   = ST_XFER;
          end
        end
      end
      ST_XFER: begin
        if (xfer_ready) begin
          log_d   = log_q + (AW+1)'(size);
          moved_d = moved_q + (LEN_W+1)'(size);
          st_d    = ST_CHECK;
        end
      end
      ST_FINISH: st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      st_q    <= ST_IDLE;
      log_q   <= '0;
      end_q   <= '0;
      moved_q <= '0;
      len_q   <= '0;
      wr_q    <= 1'b0;
      ferr_q  <= 1'b0;
      fclr_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      log_q   <= log_d;
      end_q   <= end_d;
      moved_q <= moved_d;
      len_q   <= len_d;
      wr_q    <= wr_d;
      ferr_q  <= ferr_d;
      fclr_q  <= fclr_d;
    end
  end

  assign tbl_rd_req = (st_q == ST_LOOKUP);
  assign xfer_valid = (st_q == ST_XFER);
  assign xfer_addr  = phys;
  assign xfer_len   = size;
  assign xfer_write = wr_q;
  assign done       = (st_q == ST_FINISH);
  assign done_err   = ferr_q;
  assign done_bytes = moved_q[LEN_W-1:0];
  assign clr_count  = done && fclr_q;

  // R11: an offered transfer holds until it is taken
  a_r11_xfer_hold: assert property (@(posedge clk) disable iff (!rst_s_n)
    (xfer_valid && !xfer_ready) |=>
      (xfer_valid && $stable(xfer_addr) && $stable(xfer_len)));

  // R7: long bursts start on a long-burst boundary
  a_r7_big_align: assert property (@(posedge clk) disable iff (!rst_s_n)
    (xfer_valid && xfer_len == BL_LOG2'(BIG_N)) |->
      (xfer_addr[BL_LOG2-1:0] == '0));

  // R7: short bursts start on a short-burst boundary
  a_r7_small_align: assert property (@(posedge clk) disable iff (!rst_s_n)
    (xfer_valid && xfer_len == BL_LOG2'(SMALL_N)) |->
      (xfer_addr[BS_LOG2-1:0] == '0));

  // R8: a transfer never carries the request past its length
  a_r8_len_bound: assert property (@(posedge clk) disable iff (!rst_s_n)
    xfer_valid |-> (moved_q + (LEN_W+1)'(xfer_len) <= len_q));

  // R9: done is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_s_n)
    done |=> !done);

  // R5/R6: no table traffic or transfer while idle
  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_s_n)
    (st_q == ST_IDLE) |-> (!xfer_valid && !tbl_rd_req));

endmodule

// File: tb/pgxl_dma_chan_test.sv
module pgxl_dma_chan_test;

  localparam logic [31:0] TBASE = 32'h0010_0000;

  typedef struct packed {
    logic [31:0] start;
    logic [31:0] count;
    logic [15:0] len;
    logic [15:0] exp_bytes;
    logic [15:0] exp_xfers;
    logic [7:0]  exp_lookups;
    logic [31:0] exp_first;
  } vec_t;

  // Physical page for table slot p is p*7+3; low 12 entry bits are junk.
  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{32'h0000_1000, 32'd300, 16'd300, 16'd300, 16'd18, 8'd1, 32'h0000_A000},
    '{32'h0000_0FFE, 32'd4,   16'd4,   16'd4,   16'd4,  8'd2, 32'h0000_3FFE},
    '{32'h0000_3005, 32'd100, 16'd3,   16'd3,   16'd3,  8'd1, 32'h0001_8005},
    '{32'h0000_3000, 32'd0,   16'd8,   16'd0,   16'd0,  8'd0, 32'h0000_0000},
    '{32'h0000_4010, 32'd20,  16'd20,  16'd20,  16'd6,  8'd1, 32'h0001_F010},
    '{32'h0000_2000, 32'd10,  16'd300, 16'd255, 16'd1,  8'd1, 32'h0001_1000}
  };

  logic        clk;
  logic        rst_n;
  logic        big_endian;
  logic        reg_wr;
  logic [2:0]  reg_idx;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        req_start;
  logic        req_to_mem;
  logic [15:0] req_len;
  logic        tbl_rd_req;
  logic [31:0] tbl_rd_addr;
  logic        tbl_rd_valid;
  logic [31:0] tbl_rd_data;
  logic        tbl_rd_err;
  logic        xfer_valid;
  logic        xfer_ready;
  logic [31:0] xfer_addr;
  logic [7:0]  xfer_len;
  logic        xfer_write;
  logic        done;
  logic        done_err;
  logic [15:0] done_bytes;

  logic [31:0] err_addr;
  logic        tog;
  int          n_vec;
  int          n_bad;
  bit          finished;

  pgxl_dma_chan uut (
    .clk(clk), .rst_n(rst_n), .big_endian(big_endian),
    .reg_wr(reg_wr), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .req_start(req_start), .req_to_mem(req_to_mem),
    .req_len(req_len), .tbl_rd_req(tbl_rd_req), .tbl_rd_addr(tbl_rd_addr),
    .tbl_rd_valid(tbl_rd_valid), .tbl_rd_data(tbl_rd_data),
    .tbl_rd_err(tbl_rd_err), .xfer_valid(xfer_valid), .xfer_ready(xfer_ready),
    .xfer_addr(xfer_addr), .xfer_len(xfer_len), .xfer_write(xfer_write),
    .done(done), .done_err(done_err), .done_bytes(done_bytes)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Memory-side models
  function automatic logic [31:0] table_lanes(input logic [31:0] a, input logic be);
    logic [31:0] p, pp, e;
    p  = (a - TBASE) >> 3;
    pp = p * 7 + 3;
    e  = {pp[19:0], 12'hABC};
    return be ? {e[7:0], e[15:8], e[23:16], e[31:24]} : e;
  endfunction

  assign tbl_rd_valid = tbl_rd_req;
  assign tbl_rd_data  = table_lanes(tbl_rd_addr, big_endian);
  assign tbl_rd_err   = tbl_rd_req && (tbl_rd_addr == err_addr);
  assign xfer_ready   = xfer_valid && tog;

  always @(negedge clk) tog <= ~tog;

  int          nx, nl;
  int          xsum;
  logic        xwr_last;
  logic [31:0] xlog [64];
  logic [31:0] llog [64];

  always @(posedge clk) begin
    if (xfer_valid && xfer_ready) begin
      xlog[nx % 64] <= xfer_addr;
      xsum          <= xsum + int'(xfer_len);
      xwr_last      <= xfer_write;
      nx            <= nx + 1;
    end
    if (tbl_rd_req && tbl_rd_valid) begin
      llog[nl % 64] <= tbl_rd_addr;
      nl            <= nl + 1;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic wreg(input logic [2:0] i, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_idx = i; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rreg(input logic [2:0] i, output logic [31:0] d);
    @(negedge clk);
    reg_idx = i;
    #1 d = reg_rdata;
  endtask

  logic [15:0] got_bytes;
  logic        got_err;
  int          snap_x, snap_l, snap_s;

  task automatic request(input logic to_mem, input logic [15:0] len);
    bit seen;
    seen = 0;
    snap_x = nx; snap_l = nl; snap_s = xsum;
    @(negedge clk);
    req_start = 1'b1; req_to_mem = to_mem; req_len = len;
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk);
      req_start = 1'b0;
      if (done) begin
        seen = 1;
        got_bytes = done_bytes;
        got_err   = done_err;
        break;
      end
    end
    chk("R9", "done seen", 32'(seen), 32'd1);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    n_vec = 0; n_bad = 0; finished = 0;
    nx = 0; nl = 0; xsum = 0; xwr_last = 1'b0; tog = 1'b0;
    rst_n = 1'b0; big_endian = 1'b0; reg_wr = 1'b0; reg_idx = '0;
    reg_wdata = '0; req_start = 1'b0; req_to_mem = 1'b0; req_len = '0;
    err_addr = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Reset state
    chk("R9", "reset done", 32'(done), 32'd0);
    chk("R11", "reset xfer_valid", 32'(xfer_valid), 32'd0);
    chk("R4", "reset tbl_rd_req", 32'(tbl_rd_req), 32'd0);
    for (int i = 0; i < 6; i++) begin
      rreg(3'(i), rd);
      chk("R1", "reset register", rd, 32'd0);
    end

    // R1: storage-only registers and unmapped indices
    wreg(3'd0, 32'hDEAD_0001);
    wreg(3'd5, 32'h0000_1234);
    rreg(3'd0, rd); chk("R1", "mode readback", rd, 32'hDEAD_0001);
    rreg(3'd5, rd); chk("R1", "limit readback", rd, 32'h0000_1234);
    wreg(3'd7, 32'hFFFF_FFFF);
    rreg(3'd7, rd); chk("R1", "index 7 reads zero", rd, 32'd0);
    rreg(3'd6, rd); chk("R1", "index 6 reads zero", rd, 32'd0);

    // Vector table: device-to-memory transfers
    wreg(3'd4, TBASE);
    wreg(3'd1, 32'h1);
    for (int v = 0; v < NVEC; v++) begin
      wreg(3'd3, VECS[v].start);
      wreg(3'd2, VECS[v].count);
      request(1'b1, VECS[v].len);
      chk("R9", "done_bytes", 32'(got_bytes), 32'(VECS[v].exp_bytes));
      chk("R10", "no error", 32'(got_err), 32'd0);
      chk("R7", "transfer count", 32'(nx - snap_x), 32'(VECS[v].exp_xfers));
      chk("R8", "bytes issued", 32'(xsum - snap_s), 32'(VECS[v].exp_bytes));
      chk("R4", "lookups", 32'(nl - snap_l), 32'(VECS[v].exp_lookups));
      if (VECS[v].exp_lookups != 0)
        chk("R2", "first table address", llog[snap_l % 64],
            TBASE + ((VECS[v].start >> 12) * 8));
      if (VECS[v].exp_xfers != 0) begin
        chk("R3", "first physical address", xlog[snap_x % 64], VECS[v].exp_first);
        chk("R11", "write flag", 32'(xwr_last), 32'd1);
      end
      rreg(3'd2, rd); chk("R9", "count cleared", rd, 32'd0);
    end
    // R4: second lookup of the page-crossing vector hits slot 1
    wreg(3'd3, 32'h0000_0FFE); wreg(3'd2, 32'd4);
    request(1'b1, 16'd4);
    chk("R4", "page-cross lookup address", llog[(snap_l + 1) % 64], TBASE + 32'd8);
    chk("R3", "page-cross physical address", xlog[(snap_x + 2) % 64], 32'h0000_A000);

    // R2: big-endian table entries
    big_endian = 1'b1;
    wreg(3'd3, 32'h0000_5000); wreg(3'd2, 32'd1);
    request(1'b1, 16'd1);
    chk("R2", "big-endian physical address", xlog[snap_x % 64], 32'h0002_6000);
    big_endian = 1'b0;

    // R5: wrong direction is refused
    wreg(3'd3, 32'h0000_3005); wreg(3'd2, 32'd50); wreg(3'd1, 32'h1);
    request(1'b0, 16'd8);
    chk("R5", "refused bytes", 32'(got_bytes), 32'd0);
    chk("R5", "refused transfers", 32'(nx - snap_x), 32'd0);
    chk("R5", "refused lookups", 32'(nl - snap_l), 32'd0);
    rreg(3'd2, rd); chk("R5", "count kept", rd, 32'd50);

    // R6: run bit clear refuses a request in the matching direction
    wreg(3'd1, 32'h2);
    request(1'b0, 16'd8);
    chk("R6", "stopped bytes", 32'(got_bytes), 32'd0);
    chk("R6", "stopped transfers", 32'(nx - snap_x), 32'd0);
    rreg(3'd2, rd); chk("R6", "count kept", rd, 32'd50);

    // R5: memory-to-device accepted when bit 1 set
    wreg(3'd1, 32'h3); wreg(3'd2, 32'd1);
    request(1'b0, 16'd1);
    chk("R5", "mem-to-dev bytes", 32'(got_bytes), 32'd1);
    chk("R11", "mem-to-dev write flag", 32'(xwr_last), 32'd0);

    // R10: table fault on the second page
    wreg(3'd1, 32'h1);
    wreg(3'd3, 32'h0000_0FFF); wreg(3'd2, 32'd2);
    err_addr = TBASE + 32'd8;
    request(1'b1, 16'd2);
    chk("R10", "fault flag", 32'(got_err), 32'd1);
    chk("R10", "fault bytes", 32'(got_bytes), 32'd1);
    chk("R10", "fault transfers", 32'(nx - snap_x), 32'd1);
    rreg(3'd2, rd); chk("R10", "count kept", rd, 32'd2);
    err_addr = 32'hFFFF_FFFF;

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule